// File: doc/BRIEF.md
# SONET/SDH Frame Aligner with Severely Errored Frame Detection

The block takes a byte-wide receive stream whose byte boundaries do not have to line up with the octets of the SONET/SDH frame. It looks for the framing bytes (A1 = 0xF6 followed by A2 = 0x28) at all eight bit offsets at the same time. When it finds them it keeps the winning offset and starts a frame-position counter. From then on it emits realigned bytes and a one-cycle pulse on the first A1 byte of every frame. At each expected pattern position it compares the selected part of the pattern again. Any bit error gives a one-cycle frame-error pulse, and four errored frames in a row raise the Severely Errored Frame (SEF) alarm.

Acquisition is level-sensitive. While the acquisition enable is high, the block keeps hunting and realigns to any pattern it finds. The usual connection ties the enable to the SEF output, so that hunting runs only while the alarm is up. A loss-of-signal input zeroes the incoming data and forces SEF on the next clock. The rate select sets the frame length and the number of A1/A2 bytes. The pattern-length select chooses how many bits around the A1/A2 boundary are compared, or switches detection off.

Top module: `sonet_framer_sef`

## Requirements
- R1: In reset and on the first cycle after it, sef is 1 and fr_start, fr_err and al_byte are all 0.
- R2: With acq_en high, the block locks to the pattern at any bit offset 0 to 7. From then on fr_start pulses with al_byte = 0xF6 (the first A1 of a frame), and the byte just before it is the last byte of the previous frame.
- R3: With acq_en tied to sef after reset, sef is still 1 after the first good frame and is 0 after the second good frame.
- R4: A frame with one or more bit errors in the checked pattern gives exactly one one-cycle fr_err pulse. A frame without such errors gives none.
- R5: sef rises on the fourth consecutive errored frame and not before. A good frame clears both the error run and sef.
- R6: The checked bits are chosen by len_sel. With 00 (12 bits) they are the low nibble of the last A1 and the first A2. With 10 (24 bits) they are the last A1 and the first two A2. With 01 (48 bits) they are the last three A1 and the first three A2. An error in the top bit of the third-from-last A1 is therefore reported only with 01.
- R7: With len_sel = 11, detection is off: there are no pattern checks, no fr_err and no search, and sef keeps its value.
- R8: While los is high, sef is 1 from the next clock edge and the incoming data is treated as zero, so al_byte becomes 0.
- R9: While acq_en is low, the block never searches. After a reset it stays out of frame, with sef = 1 and no fr_start.
- R10: rate_sel sets the frame length and the A1/A2 byte count: 01 for the lowest rate (3 bytes each), 10 for the middle rate (12 each) and 00 for the highest rate (48 each). The value 11 behaves as 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Line rate: 01 lowest, 10 middle, 00 highest, 11 as 01 |
| len_sel | input | 2 | Checked pattern: 00 = 12 bits, 10 = 24, 01 = 48, 11 = off |
| acq_en | input | 1 | Level-sensitive hunt enable, normally tied to sef |
| los | input | 1 | Loss of signal: zeroes the data and forces SEF |
| rx_byte | input | 8 | Unaligned receive byte |
| al_byte | output | 8 | Realigned receive byte |
| fr_start | output | 1 | One-cycle pulse on the first A1 byte of a frame |
| fr_err | output | 1 | One-cycle pulse for an errored framing pattern |
| sef | output | 1 | Severely Errored Frame alarm |

## Verification
The hardest state to reach is a run of errored frames while the block is already in frame. This needs a clean lock first, followed by frames whose pattern carries a bit error placed inside or just outside the selected mask. The bench therefore locks with acq_en tied to sef, which also stops hunting once the alarm clears. It then sends frames with one flipped bit in a chosen A1 byte, counts fr_err pulses and reads sef after every frame. All eight bit offsets are produced by shifting the logical byte stream by a chosen number of bits before it is applied.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    LEN12   = 2'b00,
    LEN48   = 2'b01,
    LEN24   = 2'b10,
    LEN_OFF = 2'b11
  } patlen_e;

  localparam logic [7:0] A1_BYTE  = 8'hF6;
  localparam logic [7:0] A2_BYTE  = 8'h28;
  localparam int         WIN_W    = 48;
  localparam logic [WIN_W-1:0] FRAME_PAT =
    {A1_BYTE, A1_BYTE, A1_BYTE, A2_BYTE, A2_BYTE, A2_BYTE};

  // Selected bits of the six-byte window (oldest byte on the left).
  function automatic logic [WIN_W-1:0] pat_mask(patlen_e m);
    case (m)
      LEN12:   pat_mask = 48'h00000F_FF0000;
      LEN24:   pat_mask = 48'h0000FF_FFFF00;
      LEN48:   pat_mask = 48'hFFFFFF_FFFFFF;
      default: pat_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sfd_window.sv
module sfd_window
  import sfd_pkg::*;
#(
  parameter int OFFSETS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             los,
  input  logic [7:0]       din,
  input  logic [WIN_W-1:0] mask,
  input  logic [2:0]       sel,
  output logic [OFFSETS-1:0] hit_vec,
  output logic             held_ok,
  output logic [7:0]       aligned
);
  localparam int HIST_W = WIN_W + OFFSETS - 1;

  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_W-9:0], (los ? 8'h00 : din)};
  end

  for (genvar j = 0; j < OFFSETS; j++) begin : g_off
    assign hit_vec[j] = (((hist[j +: WIN_W] ^ FRAME_PAT) & mask) == '0);
  end

  assign held_ok = hit_vec[sel];
  assign aligned = hist[sel +: 8];
endmodule

// File: rtl/sfd_position.sv
module sfd_position #(
  parameter int LEN_STS3  = 2430,
  parameter int LEN_STS12 = 9720,
  parameter int LEN_STS48 = 38880,
  parameter int A1_STS3   = 3,
  parameter int A1_STS12  = 12,
  parameter int A1_STS48  = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       anchor,
  output logic       at_check,
  output logic       at_start
);
  localparam int MAXLEN = (LEN_STS48 > LEN_STS12) ?
                          ((LEN_STS48 > LEN_STS3) ? LEN_STS48 : LEN_STS3) :
                          ((LEN_STS12 > LEN_STS3) ? LEN_STS12 : LEN_STS3);
  localparam int POS_W = $clog2(MAXLEN);

  logic [POS_W-1:0] pos, last_pos, chk_pos;

  always_comb begin
    case (rate_sel)
      2'b10: begin
        last_pos = POS_W'(LEN_STS12 - 1);
        chk_pos  = POS_W'(A1_STS12 + 2);
      end
      2'b00: begin
        last_pos = POS_W'(LEN_STS48 - 1);
        chk_pos  = POS_W'(A1_STS48 + 2);
      end
      default: begin
        last_pos = POS_W'(LEN_STS3 - 1);
        chk_pos  = POS_W'(A1_STS3 + 2);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  pos <= '0;
    else if (anchor)          pos <= chk_pos + 1'b1;
    else if (pos == last_pos) pos <= '0;
    else                      pos <= pos + 1'b1;
  end

  assign at_check = (pos == chk_pos);
  assign at_start = (pos == '0);
endmodule

// File: rtl/sfd_sef.sv
module sfd_sef #(
  parameter int SEF_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic los,
  input  logic check_bad,
  input  logic check_good,
  output logic sef
);
  localparam int CNT_W = (SEF_FRAMES > 2) ? $clog2(SEF_FRAMES) : 1;
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(SEF_FRAMES - 1);

  logic [CNT_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sef <= 1'b1;
      run <= '0;
    end else if (los) begin
      sef <= 1'b1;
      run <= RUN_MAX;
    end else if (check_bad) begin
      if (run == RUN_MAX) sef <= 1'b1;
      else                run <= run + 1'b1;
    end else if (check_good) begin
      sef <= 1'b0;
      run <= '0;
    end
  end
endmodule

// File: rtl/sonet_framer_sef.sv
module sonet_framer_sef
  import sfd_pkg::*;
#(
  parameter int LEN_STS3   = 2430,
  parameter int LEN_STS12  = 9720,
  parameter int LEN_STS48  = 38880,
  parameter int A1_STS3    = 3,
  parameter int A1_STS12   = 12,
  parameter int A1_STS48   = 48,
  parameter int SEF_FRAMES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic [1:0] len_sel,
  input  logic       acq_en,
  input  logic       los,
  input  logic [7:0] rx_byte,
  output logic [7:0] al_byte,
  output logic       fr_start,
  output logic       fr_err,
  output logic       sef
);
  localparam int OFFSETS = 8;

  patlen_e          mode;
  logic [WIN_W-1:0] mask;
  logic             det_on;
  logic [OFFSETS-1:0] hit_vec;
  logic             held_ok;
  logic [7:0]       aligned;
  logic [2:0]       sel, hit_idx;
  logic             locked;
  logic             at_check, at_start;
  logic             chk, good, bad, hunt;

  assign mode   = patlen_e'(len_sel);
  assign det_on = (mode != LEN_OFF);
  assign mask   = pat_mask(mode);

  sfd_window #(.OFFSETS(OFFSETS)) u_win (
    .clk(clk), .rst(rst), .los(los), .din(rx_byte), .mask(mask),
    .sel(sel), .hit_vec(hit_vec), .held_ok(held_ok), .aligned(aligned)
  );

  sfd_position #(
    .LEN_STS3(LEN_STS3), .LEN_STS12(LEN_STS12), .LEN_STS48(LEN_STS48),
    .A1_STS3(A1_STS3), .A1_STS12(A1_STS12), .A1_STS48(A1_STS48)
  ) u_pos (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .anchor(hunt),
    .at_check(at_check), .at_start(at_start)
  );

  sfd_sef #(.SEF_FRAMES(SEF_FRAMES)) u_sef (
    .clk(clk), .rst(rst), .los(los), .check_bad(bad), .check_good(good),
    .sef(sef)
  );

  // Lowest matching offset wins.
  always_comb begin
    hit_idx = '0;
    for (int j = OFFSETS - 1; j >= 0; j--)
      if (hit_vec[j]) hit_idx = 3'(j);
  end

  assign chk  = locked && at_check && det_on;
  assign good = chk && held_ok;
  assign bad  = chk && !held_ok;
  assign hunt = det_on && acq_en && (|hit_vec) && !good;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      sel      <= '0;
      al_byte  <= '0;
      fr_start <= 1'b0;
      fr_err   <= 1'b0;
    end else begin
      if (hunt) begin
        locked <= 1'b1;
        sel    <= hit_idx;
      end
      al_byte  <= aligned;
      fr_start <= locked && at_start;
      fr_err   <= bad;
    end
  end
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker (
  input logic       clk,
  input logic       rst,
  input logic       los,
  input logic [1:0] len_sel,
  input logic       fr_start,
  input logic       fr_err,
  input logic       sef
);
  assert_los_sef_R8: assert property (@(posedge clk) disable iff (rst)
    los |=> sef);

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    fr_err |=> !fr_err);

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    fr_start |=> !fr_start);

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (len_sel == 2'b11) |=> !fr_err);

  assert_sef_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sef) |-> (fr_err || $past(los)));
endmodule

bind sonet_framer_sef sfd_checker u_chk (
  .clk(clk), .rst(rst), .los(los), .len_sel(len_sel),
  .fr_start(fr_start), .fr_err(fr_err), .sef(sef)
);

// File: tb/tb_sonet_framer_sef.sv
module tb_sonet_framer_sef;
  localparam int L3 = 64, L12 = 96, L48 = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rate_sel = 2'b01, len_sel = 2'b10;
  logic acq_manual = 1'b0, tie = 1'b1, los = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] al_byte;
  logic fr_start, fr_err, sef, acq_en;

  assign acq_en = tie ? sef : acq_manual;

  always #5 clk = ~clk;

  sonet_framer_sef #(.LEN_STS3(L3), .LEN_STS12(L12), .LEN_STS48(L48)) dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .len_sel(len_sel),
    .acq_en(acq_en), .los(los), .rx_byte(rx_byte), .al_byte(al_byte),
    .fr_start(fr_start), .fr_err(fr_err), .sef(sef)
  );

  int tests = 0, fails = 0;
  int fs_cnt, fe_cnt, al_err;
  logic [7:0] prev_out;
  int kbits = 0;
  logic [7:0] prev_l = 8'h00;

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      fs_cnt = 0; fe_cnt = 0; al_err = 0; prev_out = 8'h00;
    end else begin
      if (fr_start) begin
        fs_cnt++;
        if (al_byte != 8'hF6 || prev_out != 8'h55) al_err++;
      end
      if (fr_err) fe_cnt++;
      prev_out = al_byte;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int a1n(input logic [1:0] r);
    return (r == 2'b10) ? 12 : (r == 2'b00) ? 48 : 3;
  endfunction

  function automatic int flen(input logic [1:0] r);
    return (r == 2'b10) ? L12 : (r == 2'b00) ? L48 : L3;
  endfunction

  task automatic send_byte(input logic [7:0] l);
    logic [15:0] c;
    c = {prev_l, l} >> kbits;
    @(negedge clk);
    rx_byte = c[7:0];
    prev_l = l;
  endtask

  // kind 0: clean, 1: flip LSB of last A1, 2: flip MSB of third-from-last A1
  task automatic send_frame(input int kind);
    int n, len;
    logic [7:0] b;
    n = a1n(rate_sel);
    len = flen(rate_sel);
    for (int p = 0; p < len; p++) begin
      if (p < n)             b = 8'hF6;
      else if (p < 2 * n)    b = 8'h28;
      else if (p == len - 1) b = 8'h55;
      else                   b = 8'h00;
      if (kind == 1 && p == n - 1) b = b ^ 8'h01;
      if (kind == 2 && p == n - 3) b = b ^ 8'h80;
      send_byte(b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic lock_up();
    tie = 1'b1;
    do_reset();
    send_frame(0);
    send_frame(0);
  endtask

  // {rate[7:6], len_sel[5:4], 1'b0, offset[2:0]}
  localparam logic [7:0] VEC [0:6] = '{8'h40, 8'h63, 8'h57, 8'hA5, 8'h11, 8'h06, 8'hE2};

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(sef == 1'b1, "R1 sef in reset", int'(sef), 1);
    rst = 1'b0;
    @(negedge clk);
    check(sef == 1'b1 && fr_start == 1'b0 && fr_err == 1'b0 && al_byte == 8'h00,
          "R1 state after reset", int'({sef, fr_start, fr_err}), 4);

    // R2 R3 R10: acquisition at each table entry
    for (int v = 0; v < 7; v++) begin
      rate_sel = VEC[v][7:6];
      len_sel  = VEC[v][5:4];
      kbits    = int'(VEC[v][2:0]);
      tie = 1'b1;
      do_reset();
      send_frame(0);
      check(sef == 1'b1, "R3 sef after one good frame", int'(sef), 1);
      send_frame(0);
      check(sef == 1'b0, "R3 sef after two good frames", int'(sef), 0);
      send_frame(0);
      send_frame(0);
      check(fs_cnt == 3, "R2 R10 frame starts", fs_cnt, 3);
      check(al_err == 0, "R2 alignment of start byte", al_err, 0);
      check(fe_cnt == 0, "R4 no errors on clean frames", fe_cnt, 0);
    end

    // R5: four consecutive errored frames
    rate_sel = 2'b10; len_sel = 2'b10; kbits = 3;
    lock_up();
    for (int i = 1; i <= 4; i++) begin
      send_frame(1);
      check(fe_cnt == i, "R4 one pulse per errored frame", fe_cnt, i);
      check(sef == (i == 4), "R5 sef on fourth errored frame", int'(sef), int'(i == 4));
    end

    // R5: a good frame restarts the run
    lock_up();
    repeat (3) send_frame(1);
    send_frame(0);
    repeat (3) send_frame(1);
    check(sef == 1'b0, "R5 good frame restarts run", int'(sef), 0);
    check(fe_cnt == 6, "R4 errored frame count", fe_cnt, 6);
    send_frame(0);
    check(sef == 1'b0 && fe_cnt == 6, "R4 clean frame after errors", fe_cnt, 6);

    // R6: mask width
    len_sel = 2'b00; kbits = 5;
    lock_up();
    send_frame(2);
    send_frame(2);
    check(fe_cnt == 0, "R6 12-bit ignores outer A1 bit", fe_cnt, 0);
    len_sel = 2'b10;
    send_frame(2);
    check(fe_cnt == 0, "R6 24-bit ignores outer A1 bit", fe_cnt, 0);
    len_sel = 2'b01;
    send_frame(2);
    check(fe_cnt == 1, "R6 48-bit sees outer A1 bit", fe_cnt, 1);

    // R7: detection off
    len_sel = 2'b10;
    lock_up();
    len_sel = 2'b11;
    repeat (5) send_frame(1);
    check(fe_cnt == 0, "R7 no frame errors when off", fe_cnt, 0);
    check(sef == 1'b0, "R7 sef held when off", int'(sef), 0);

    // R8: loss of signal
    len_sel = 2'b10;
    lock_up();
    @(negedge clk);
    rx_byte = 8'hF6;
    los = 1'b1;
    @(negedge clk);
    check(sef == 1'b1, "R8 sef one edge after los", int'(sef), 1);
    repeat (10) @(negedge clk);
    check(al_byte == 8'h00, "R8 data forced to zero", int'(al_byte), 0);
    los = 1'b0;

    // R9: enable low never acquires
    tie = 1'b0; acq_manual = 1'b0; kbits = 0;
    do_reset();
    repeat (3) send_frame(0);
    check(sef == 1'b1, "R9 stays out of frame", int'(sef), 1);
    check(fs_cnt == 0, "R9 no frame start", fs_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule